// File: doc/BRIEF.md
# Class-D power stage fault supervisor

This block is the digital protection supervisor for a switching power stage with four outputs. For each output it takes two overcurrent comparator flags, one low and one high, and the PWM drive signal. Shared inputs are three supply-good flags, an unsigned temperature code in degrees Celsius and an active-low power-down pin. From these it produces a per-output enable that turns both switches of that output on or off. When the enable is off, the output floats. It also produces four per-channel error pull-down enables and one over-temperature warning pull-down enable. A value of 1 on a pull-down enable drives the matching open-drain line low.

The two overcurrent thresholds are handled differently. A low-threshold trip is only reported, and only while it lasts. A high-threshold trip shuts its output down and holds it off. The controller clears the fault by stopping PWM edges on that channel once the current is back to normal. Supply and thermal faults do not latch: they disable every output and pull every error line low, and operation returns when the condition clears. All asynchronous inputs pass through two-flop synchronizers. The glitch filter, the supply settling time and the PWM-idle timeout are counters on the system clock, and parameters set their lengths.

Top module: `pstage_fault_sup`

## Requirements
- R1: While a channel's low overcurrent flag is 1, that channel's err_pd bit is 1 and its out_en bit is unchanged. Once the flag returns to 0, err_pd returns to 0.
- R2: A 1 on a channel's high overcurrent flag sets a latched fault that forces that channel's out_en bit to 0 and its err_pd bit to 1. The fault stays set after the flag returns to 0 for as long as PWM edges keep arriving on that channel.
- R3: A latched fault clears only when the high flag is 0 and the channel's PWM input has had no edge for IDLE_CYC consecutive clocks. It does not clear while the high flag is still 1. Once both conditions hold, it clears within a few clocks.
- R4: While pdn_n is 0, every out_en bit is 0 and all latched faults are cleared. When pdn_n returns to 1, outputs come back without the earlier latched faults. pdn_n by itself does not raise err_pd.
- R5: otw_pd becomes 1 when the temperature code is at or above WARN_ON (125). It returns to 0 only when the code is at or below WARN_ON-WARN_HYS (105). The warning alone does not change out_en or err_pd.
- R6: When the temperature code is at or above SHUT_ON (140), every out_en bit is 0, every err_pd bit is 1 and otw_pd is 1. Outputs resume by themselves when the code is at or below SHUT_ON-SHUT_HYS (110).
- R7: A low reading on any of hv_ok, gd_ok or lg_ok forces every out_en bit to 0 and every err_pd bit to 1. Outputs resume after all three flags have been good for STABLE_CYC consecutive clocks.
- R8: A low pulse on gd_ok or lg_ok that is shorter than GLITCH_CYC clocks has no effect. A low pulse of one clock on hv_ok is acted on.
- R9: Out of reset, out_en is 0, err_pd is all ones and otw_pd is 0. Outputs stay disabled until the supplies have been good for STABLE_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdn_n | input | 1 | Active-low power-down and mute |
| pwm_in | input | NCH | PWM drive, one bit per output |
| oc_lo | input | NCH | Low-threshold overcurrent flags |
| oc_hi | input | NCH | High-threshold overcurrent flags |
| hv_ok | input | 1 | High-voltage rail good |
| gd_ok | input | 1 | Gate-drive rail good |
| lg_ok | input | 1 | Logic rail good |
| temp_c | input | TEMP_W | Die temperature, unsigned degrees Celsius |
| out_en | output | NCH | Per-output switch enable (0 means floating) |
| err_pd | output | NCH | Error line pull-down enables (1 means line low) |
| otw_pd | output | 1 | Over-temperature warning pull-down enable |

## Verification
A latch bit stuck at 1 shows up as a channel that stays disabled with its error line low after the recovery sequence, and that appears within a few clocks of the PWM-idle timeout. A hysteresis bit that is lost or inverted shows up at the warning or enable pins at the first temperature step that lands inside the hysteresis band. A wrong filter or settling counter shifts the moment the error lines fall or rise by whole clocks. The bench therefore samples at points on both sides of each counter limit. A long random run holds every input pattern for several clocks before comparing against a reference model, so a corrupted latch or hysteresis state shows up at the next sample point.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int NSUP = 3;

    typedef enum int {
        SUP_HV = 0,
        SUP_GD = 1,
        SUP_LG = 2
    } sup_idx_e;

    // Supplies whose flags are glitch filtered (gate-drive and logic rails).
    localparam logic [NSUP-1:0] SUP_FILT_MASK = 3'b110;

    typedef struct packed {
        logic warn;
        logic shut;
    } therm_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta = din;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stab;
endmodule

// File: rtl/pfs_chan.sv
module pfs_chan #(
    parameter int IDLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_ok,
    input  logic pwm_s,
    input  logic oc_hi_s,
    output logic oc_lat
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYC);

    typedef struct packed {
        logic          lat;
        logic          pwm_prev;
        logic [CW-1:0] idle_cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  idle;

    assign idle = (st_q.idle_cnt == IDLE_LIM);

    always_comb begin
        st_d          = st_q;
        st_d.pwm_prev = pwm_s;
        if (pwm_s != st_q.pwm_prev)
            st_d.idle_cnt = '0;
        else if (!idle)
            st_d.idle_cnt = st_q.idle_cnt + CW'(1);

        if (!pdn_ok)
            st_d.lat = 1'b0;
        else if (oc_hi_s)
            st_d.lat = 1'b1;
        else if (idle)
            st_d.lat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc_lat = st_q.lat;

    AST_HI_TRIP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_ok && oc_hi_s) |=> oc_lat); // R2

    AST_CLEAR_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_lat) |-> ($past(!pdn_ok) || $past(!oc_hi_s && idle))); // R3
endmodule

// File: rtl/pfs_supmon.sv
module pfs_supmon
    import pfs_pkg::*;
#(
    parameter int GLITCH_CYC = 5,
    parameter int STABLE_CYC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUP-1:0] flags_s,
    output logic            sup_ok
);
    localparam int GW = $clog2(GLITCH_CYC + 1);
    localparam int SW = $clog2(STABLE_CYC + 1);
    localparam logic [GW-1:0] G_LIM = GW'(GLITCH_CYC);
    localparam logic [SW-1:0] S_LIM = SW'(STABLE_CYC);

    typedef struct packed {
        logic [NSUP-1:0][GW-1:0] low_cnt;
        logic [SW-1:0]           good_cnt;
    } sup_t;

    sup_t            st_d, st_q;
    logic [NSUP-1:0] flt;

    for (genvar i = 0; i < NSUP; i++) begin : g_flt
        if (SUP_FILT_MASK[i]) begin : g_filtered
            assign flt[i] = (st_q.low_cnt[i] == G_LIM);

            AST_FILT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                flt[i] |-> $past(!flags_s[i])); // R8
        end else begin : g_direct
            assign flt[i] = !flags_s[i] || (st_q.low_cnt[i] == G_LIM);
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSUP; i++) begin
            if (flags_s[i])
                st_d.low_cnt[i] = '0;
            else if (st_q.low_cnt[i] != G_LIM)
                st_d.low_cnt[i] = st_q.low_cnt[i] + GW'(1);
        end
        if (|flt)
            st_d.good_cnt = '0;
        else if (st_q.good_cnt != S_LIM)
            st_d.good_cnt = st_q.good_cnt + SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sup_ok = (st_q.good_cnt == S_LIM);

    AST_OK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        sup_ok |-> !$past(|flt)); // R7
endmodule

// File: rtl/pfs_therm.sv
module pfs_therm
    import pfs_pkg::*;
#(
    parameter int TW       = 8,
    parameter int WARN_ON  = 125,
    parameter int WARN_HYS = 20,
    parameter int SHUT_ON  = 140,
    parameter int SHUT_HYS = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_s,
    output logic          warn,
    output logic          shut
);
    localparam logic [TW-1:0] W_SET = TW'(WARN_ON);
    localparam logic [TW-1:0] W_CLR = TW'(WARN_ON - WARN_HYS);
    localparam logic [TW-1:0] S_SET = TW'(SHUT_ON);
    localparam logic [TW-1:0] S_CLR = TW'(SHUT_ON - SHUT_HYS);

    therm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (temp_s >= W_SET)      st_d.warn = 1'b1;
        else if (temp_s <= W_CLR) st_d.warn = 1'b0;
        if (temp_s >= S_SET)      st_d.shut = 1'b1;
        else if (temp_s <= S_CLR) st_d.shut = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warn = st_q.warn;
    assign shut = st_q.shut;

    AST_WARN_AT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_s >= W_SET) |=> warn); // R5

    AST_SHUT_HAS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        shut |-> warn); // R6
endmodule

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup
    import pfs_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int TEMP_W     = 8,
    parameter int WARN_ON    = 125,
    parameter int WARN_HYS   = 20,
    parameter int SHUT_ON    = 140,
    parameter int SHUT_HYS   = 30,
    parameter int IDLE_CYC   = 1000,
    parameter int GLITCH_CYC = 5,
    parameter int STABLE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic [NCH-1:0]    pwm_in,
    input  logic [NCH-1:0]    oc_lo,
    input  logic [NCH-1:0]    oc_hi,
    input  logic              hv_ok,
    input  logic              gd_ok,
    input  logic              lg_ok,
    input  logic [TEMP_W-1:0] temp_c,
    output logic [NCH-1:0]    out_en,
    output logic [NCH-1:0]    err_pd,
    output logic              otw_pd
);
    localparam int SYW = 3 * NCH + NSUP + 1;

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] err;
        logic           otw;
    } out_t;

    logic [SYW-1:0]    sy_in, sy_out;
    logic [NCH-1:0]    pwm_s, lo_s, hi_s, lat;
    logic [NSUP-1:0]   sup_s, sup_raw;
    logic              pdn_s, sup_ok, warn, shut, gflt;
    logic [TEMP_W-1:0] temp_s;
    out_t              out_d, out_q;

    always_comb begin
        sup_raw         = '0;
        sup_raw[SUP_HV] = hv_ok;
        sup_raw[SUP_GD] = gd_ok;
        sup_raw[SUP_LG] = lg_ok;
    end

    assign sy_in = {pwm_in, oc_lo, oc_hi, sup_raw, pdn_n};
    assign {pwm_s, lo_s, hi_s, sup_s, pdn_s} = sy_out;

    pfs_sync #(.W(SYW)) u_sync_flags (
        .clk(clk), .rst_n(rst_n), .din(sy_in), .dout(sy_out)
    );

    pfs_sync #(.W(TEMP_W)) u_sync_temp (
        .clk(clk), .rst_n(rst_n), .din(temp_c), .dout(temp_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pfs_chan #(.IDLE_CYC(IDLE_CYC)) u_chan (
            .clk(clk), .rst_n(rst_n), .pdn_ok(pdn_s),
            .pwm_s(pwm_s[c]), .oc_hi_s(hi_s[c]), .oc_lat(lat[c])
        );
    end

    pfs_supmon #(.GLITCH_CYC(GLITCH_CYC), .STABLE_CYC(STABLE_CYC)) u_supmon (
        .clk(clk), .rst_n(rst_n), .flags_s(sup_s), .sup_ok(sup_ok)
    );

    pfs_therm #(
        .TW(TEMP_W), .WARN_ON(WARN_ON), .WARN_HYS(WARN_HYS),
        .SHUT_ON(SHUT_ON), .SHUT_HYS(SHUT_HYS)
    ) u_therm (
        .clk(clk), .rst_n(rst_n), .temp_s(temp_s), .warn(warn), .shut(shut)
    );

    assign gflt = shut || !sup_ok;

    always_comb begin
        out_d.en  = (pdn_s && !gflt) ? ~lat : '0;
        out_d.err = gflt ? '1 : (lat | lo_s);
        out_d.otw = warn || shut;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{en: '0, err: '1, otw: 1'b0};
        else        out_q <= out_d;
    end

    assign out_en = out_q.en;
    assign err_pd = out_q.err;
    assign otw_pd = out_q.otw;

    AST_PDN_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_s |=> (out_en == '0)); // R4

    AST_GLOBAL_FAULT_ALL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        gflt |=> (&err_pd && out_en == '0)); // R6
endmodule

// File: tb/pstage_fault_sup_tb.sv
module pstage_fault_sup_tb;
    localparam int NCH  = 4;
    localparam int IDLE = 40;

    logic       clk = 1'b0;
    logic       rst_n, pdn_n, hv_ok, gd_ok, lg_ok;
    logic [3:0] pwm_in, oc_lo, oc_hi, pwm_run;
    logic [7:0] temp_c;
    wire  [3:0] out_en, err_pd;
    wire        otw_pd;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pstage_fault_sup #(
        .NCH(NCH), .TEMP_W(8), .IDLE_CYC(IDLE), .GLITCH_CYC(4), .STABLE_CYC(16)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .pwm_in(pwm_in),
        .oc_lo(oc_lo), .oc_hi(oc_hi), .hv_ok(hv_ok), .gd_ok(gd_ok),
        .lg_ok(lg_ok), .temp_c(temp_c),
        .out_en(out_en), .err_pd(err_pd), .otw_pd(otw_pd)
    );

    initial begin
        pwm_in = 4'h0;
        forever begin
            @(negedge clk);
            pwm_in = pwm_in ^ pwm_run;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = {otw_pd, err_pd, out_en};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual otw/err/en=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] model(input logic [3:0] lat, input logic [3:0] lo,
                                         input logic warn, input logic shut,
                                         input logic sok, input logic pdn);
        logic [3:0] en, er;
        en = (pdn && sok && !shut) ? ~lat : 4'h0;
        er = (shut || !sok) ? 4'hF : (lat | lo);
        return {warn || shut, er, en};
    endfunction

    function automatic logic hyst(input logic cur, input int t, input int on, input int off);
        if (t >= on)  return 1'b1;
        if (t <= off) return 1'b0;
        return cur;
    endfunction

    localparam logic [8:0] NORMAL = 9'b0_0000_1111;
    localparam logic [8:0] GFAULT = 9'b0_1111_0000;

    initial begin
        logic [3:0] m_lat;
        logic       m_warn, m_shut, seen;
        void'($urandom(32'd1234));
        rst_n = 1'b0; pdn_n = 1'b1; hv_ok = 1'b1; gd_ok = 1'b1; lg_ok = 1'b1;
        oc_lo = 4'h0; oc_hi = 4'h0; temp_c = 8'd30; pwm_run = 4'hF;

        // R9: reset state and power-up settling
        tick(3);
        check("R9 reset", GFAULT);
        rst_n = 1'b1;
        tick(6);
        check("R9 settling", GFAULT);
        tick(20);
        check("R9 settled", NORMAL);

        // R1: low threshold reports only
        oc_lo = 4'b0010; tick(6);
        check("R1 lo active", 9'b0_0010_1111);
        oc_lo = 4'h0; tick(6);
        check("R1 lo gone", NORMAL);

        // R2: high threshold latches while PWM runs
        oc_hi = 4'b0100; tick(6);
        oc_hi = 4'h0; tick(6);
        check("R2 latched", 9'b0_0100_1011);
        tick(60);
        check("R2 held with PWM", 9'b0_0100_1011);

        // R3: no clear while high flag still present, clear once gone and idle
        pwm_run = 4'b1011; oc_hi = 4'b0100; tick(60);
        check("R3 hi still set", 9'b0_0100_1011);
        oc_hi = 4'h0; tick(6);
        check("R3 cleared", NORMAL);
        pwm_run = 4'hF;
        oc_hi = 4'b1000; tick(6);
        oc_hi = 4'h0; pwm_run = 4'b0111;
        tick(25);
        check("R3 before timeout", 9'b0_1000_0111);
        tick(30);
        check("R3 after timeout", NORMAL);
        pwm_run = 4'hF; tick(4);

        // R4: power-down mutes and clears latches
        oc_hi = 4'b0001; tick(6); oc_hi = 4'h0; tick(4);
        check("R4 pre latch", 9'b0_0001_1110);
        pdn_n = 1'b0; tick(6);
        check("R4 muted", 9'b0_0000_0000);
        pdn_n = 1'b1; tick(6);
        check("R4 resumed clear", NORMAL);

        // R5: warning hysteresis, no effect on outputs
        temp_c = 8'd125; tick(6);
        check("R5 warn set", 9'b1_0000_1111);
        temp_c = 8'd110; tick(6);
        check("R5 warn hold", 9'b1_0000_1111);
        temp_c = 8'd105; tick(6);
        check("R5 warn release", NORMAL);
        temp_c = 8'd124; tick(6);
        check("R5 below trip", NORMAL);

        // R6: shutdown hysteresis, automatic resume
        temp_c = 8'd140; tick(6);
        check("R6 shutdown", 9'b1_1111_0000);
        temp_c = 8'd115; tick(6);
        check("R6 shut hold", 9'b1_1111_0000);
        temp_c = 8'd110; tick(6);
        check("R6 resume", 9'b1_0000_1111);
        temp_c = 8'd30; tick(6);
        check("R6 cool", NORMAL);

        // R7: supply faults
        hv_ok = 1'b0; tick(8);
        check("R7 hv low", GFAULT);
        hv_ok = 1'b1; tick(6);
        check("R7 hv settling", GFAULT);
        tick(20);
        check("R7 hv resume", NORMAL);
        gd_ok = 1'b0; tick(10);
        check("R7 gd low", GFAULT);
        gd_ok = 1'b1; tick(30);
        check("R7 gd resume", NORMAL);
        lg_ok = 1'b0; tick(10);
        check("R7 lg low", GFAULT);
        lg_ok = 1'b1; tick(30);
        check("R7 lg resume", NORMAL);

        // R8: glitch filter on gate-drive and logic flags, none on hv
        gd_ok = 1'b0; tick(2); gd_ok = 1'b1;
        for (int i = 0; i < 10; i++) begin tick(1); check("R8 gd glitch", NORMAL); end
        lg_ok = 1'b0; tick(2); lg_ok = 1'b1;
        for (int i = 0; i < 10; i++) begin tick(1); check("R8 lg glitch", NORMAL); end
        hv_ok = 1'b0; tick(1); hv_ok = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin tick(1); if (err_pd == 4'hF) seen = 1'b1; end
        n_chk++;
        if (!seen) begin
            n_err++;
            $display("FAIL R8 hv pulse: actual err_pd never 1111 expected 1111");
        end
        tick(30);
        check("R8 hv recovered", NORMAL);

        // Random phase, PWM always running (R1, R2, R5, R6)
        m_lat = 4'h0; m_warn = 1'b0; m_shut = 1'b0;
        for (int s = 0; s < 300; s++) begin
            int t;
            t      = int'($urandom_range(160, 95));
            temp_c = 8'(t);
            oc_lo  = 4'($urandom);
            oc_hi  = ($urandom % 10 == 0) ? (4'b0001 << ($urandom % 4)) : 4'h0;
            tick(6);
            m_lat  = m_lat | oc_hi;
            m_warn = hyst(m_warn, t, 125, 105);
            m_shut = hyst(m_shut, t, 140, 110);
            check("R2 R5 R6 random", model(m_lat, oc_lo, m_warn, m_shut, 1'b1, 1'b1));
        end

        // Final recovery: stop PWM, flags clear, latches must release (R3)
        oc_lo = 4'h0; oc_hi = 4'h0; temp_c = 8'd30; pwm_run = 4'h0;
        tick(IDLE + 20);
        check("R3 final release", NORMAL);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule